// File: doc/BRIEF.md
# Sigma-Delta Modulator Calibration Sequencer

This block is a controller that sits next to a dual-channel, single-bit sigma-delta modulator and runs the modulator's offset and gain calibration. It drives four controls toward the modulator: a reset, a zero-input control, a gain-calibration control and a range-select line. A calibration run takes these steps in turn:

1. It resets the modulator and lets it settle.
2. With the inputs zeroed, it counts the ones in each of the two bit streams over a window of power-of-two length.
3. It repeats the count with the gain-calibration control applied.

For each channel and each step it reports a signed error: the measured ones count minus the ideal count for that step.

The modulator's data-valid flag guards every counting window. If valid drops during a window, the window's counts are thrown away, the step waits through a settling period and is counted again. After a fixed number of such retries the run gives up and raises an error flag. Results belong to the range mode that was in force when they were taken. A stale flag shows that no valid result exists for the mode now selected.

Top module: `sdm_cal_seq`

## Requirements
- R1: Out of reset, `busy`, `cal_done`, `cal_error`, `mod_rst`, `zero_cal` and `gain_cal` are low, and `stale` is high. While idle, `start` sampled high asserts `mod_rst` for exactly RST_CYC cycles, and `busy` rises in the same cycle.
- R2: From the cycle after `mod_rst` falls, exactly SETTLE_CYC cycles pass before `zero_cal` rises. During a run, `mod_bip` holds the value `bip_sel` had when the run started. When idle, `mod_bip` follows `bip_sel` (1 = bipolar, 0 = unipolar).
- R3: The offset step holds `zero_cal` high, waits SETTLE_CYC cycles and then counts ones over N cycles. The error is ones minus N/2 in bipolar mode and ones minus 3N/8 in unipolar mode, reported as 21-bit two's complement on `off_err_a` and `off_err_b`.
- R4: The gain step holds `gain_cal` high, waits SETTLE_CYC cycles and counts over N cycles. The error is ones minus 5N/8, reported on `gain_err_a` and `gain_err_b`.
- R5: N = 2^L, where L is `win_log2` clamped to the range 10..20.
- R6: If `mod_valid` is low in any counting cycle, that window's counts are discarded. The same step then waits SETTLE_CYC cycles and counts a fresh window, so a later clean window gives the correct result.
- R7: The fifth discarded window of a single step ends the run: `cal_error` rises and `cal_done` pulses. `cal_error` stays high until the next start, and `stale` reads high.
- R8: `zero_cal` and `gain_cal` are never high together. Both controls, and `mod_rst`, are low in the `cal_done` cycle. `cal_done` lasts one cycle, and `busy` is low in the next cycle.
- R9: `stale` is low only after a successful run, and only while `bip_sel` equals the mode used by that run. A mode change sets it high at once.
- R10: A `start` that arrives while `busy` is high is ignored: the run is not restarted and no extra `mod_rst` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; stream bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calibration run (used only when idle) |
| bip_sel | input | 1 | Range mode request: 1 bipolar, 0 unipolar |
| win_log2 | input | 5 | Log2 of the counting window, clamped to 10..20 |
| mod_valid | input | 1 | Data-valid flag from the modulator |
| bit_a | input | 1 | Channel A bit stream |
| bit_b | input | 1 | Channel B bit stream |
| mod_rst | output | 1 | Reset to the modulator |
| zero_cal | output | 1 | Zero-input control to the modulator |
| gain_cal | output | 1 | Gain-calibration control to the modulator |
| mod_bip | output | 1 | Range select to the modulator |
| off_err_a | output | 21 | Channel A offset error, signed |
| off_err_b | output | 21 | Channel B offset error, signed |
| gain_err_a | output | 21 | Channel A gain error, signed |
| gain_err_b | output | 21 | Channel B gain error, signed |
| busy | output | 1 | Run in progress |
| cal_done | output | 1 | One-cycle end-of-run pulse |
| cal_error | output | 1 | Last run gave up after too many retries |
| stale | output | 1 | No valid result for the selected mode |

## Verification
The bench models the modulator with bit patterns of known ones density per eighth, which makes the expected counts exact for any phase. The tests aim at the cases that are easy to get wrong:

- **Window end and ideal count.** An off-by-one at the window end, or a wrong ideal count (for example using N/2 in unipolar mode), shows up directly as a nonzero or shifted error value.
- **Retry after a valid glitch.** A glitch in the gain window checks that the partial count is discarded. A design that kept it would report a smaller count.
- **Give-up path.** With valid held low, the run must end with the error flag set rather than hang.
- **Mode flip.** Toggling the mode after a good run must raise stale at once.
- **Start while busy.** A start pulse mid-run must not produce a second modulator reset.
- **Window clamp.** A window request below the minimum must be treated as 2^10.

// File: rtl/sdm_cal_pkg.sv
package sdm_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_SETTLE, ST_OFF_WAIT,
    ST_OFF_CNT, ST_GAIN_WAIT, ST_GAIN_CNT, ST_FIN
  } cal_state_t;

  // Clamp the requested window exponent into the supported range
  function automatic int unsigned clamp_log(input int unsigned lg,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (lg < lo) return lo;
    if (lg > hi) return hi;
    return lg;
  endfunction

  // Ideal ones count for a window of 2^lg cycles
  function automatic int unsigned ideal_ones(input int unsigned lg,
                                             input logic gain_step,
                                             input logic bip);
    if (gain_step) return 32'd5 << (lg - 3);
    if (bip)       return 32'd1 << (lg - 1);
    return 32'd3 << (lg - 3);
  endfunction

endpackage

// File: rtl/sdm_ones_ctr.sv
module sdm_ones_ctr #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_in,
  output logic [CW-1:0] total_next
);
  logic [CW-1:0] cnt;
  logic          add;

  assign add        = en & bit_in;
  assign total_next = cnt + CW'(add);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= total_next;
  end
endmodule

// File: rtl/sdm_cal_ctrl.sv
module sdm_cal_ctrl
  import sdm_cal_pkg::*;
#(
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 1000,
  parameter int MIN_LOG    = 10,
  parameter int MAX_LOG    = 20,
  parameter int MAX_RETRY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bip_in,
  input  logic [4:0] win_log2,
  input  logic       mod_valid,
  output logic       mod_rst,
  output logic       zero_cal,
  output logic       gain_cal,
  output logic       busy,
  output logic       done,
  output logic       fail,
  output logic       run_bip,
  output logic [4:0] run_log,
  output logic       cnt_clr,
  output logic       cnt_en,
  output logic       store_off,
  output logic       store_gain
);
  localparam int LONG = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int SW   = $clog2(LONG + 1);
  localparam int TW   = ((SW > MAX_LOG) ? SW : MAX_LOG) + 1;
  localparam int RW   = $clog2(MAX_RETRY + 1);

  cal_state_t    state;
  logic [TW-1:0] tmr;
  logic [RW-1:0] retry;
  logic [TW-1:0] win_m1;
  logic          counting, abort_evt, win_last, settle_last, rst_last;

  assign win_m1      = (TW'(1) << run_log) - TW'(1);
  assign counting    = (state == ST_OFF_CNT) || (state == ST_GAIN_CNT);
  assign abort_evt   = counting && !mod_valid;
  assign win_last    = counting && (tmr == win_m1);
  assign settle_last = (tmr == TW'(SETTLE_CYC - 1));
  assign rst_last    = (tmr == TW'(RST_CYC - 1));

  assign mod_rst    = (state == ST_RST);
  assign zero_cal   = (state == ST_OFF_WAIT) || (state == ST_OFF_CNT);
  assign gain_cal   = (state == ST_GAIN_WAIT) || (state == ST_GAIN_CNT);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
  assign cnt_clr    = !counting;
  assign cnt_en     = counting && mod_valid;
  assign store_off  = (state == ST_OFF_CNT) && mod_valid && win_last;
  assign store_gain = (state == ST_GAIN_CNT) && mod_valid && win_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      retry   <= '0;
      fail    <= 1'b0;
      run_bip <= 1'b0;
      run_log <= 5'(MIN_LOG);
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RST;
          tmr     <= '0;
          retry   <= '0;
          fail    <= 1'b0;
          run_bip <= bip_in;
          run_log <= 5'(clamp_log(32'(win_log2), MIN_LOG, MAX_LOG));
        end
        ST_RST: begin
          tmr <= rst_last ? '0 : tmr + TW'(1);
          if (rst_last) state <= ST_SETTLE;
        end
        ST_SETTLE, ST_OFF_WAIT, ST_GAIN_WAIT: begin
          tmr <= settle_last ? '0 : tmr + TW'(1);
          if (settle_last)
            state <= (state == ST_SETTLE)   ? ST_OFF_WAIT :
                     (state == ST_OFF_WAIT) ? ST_OFF_CNT  : ST_GAIN_CNT;
        end
        ST_OFF_CNT, ST_GAIN_CNT: begin
          if (abort_evt) begin
            tmr <= '0;
            if (retry == RW'(MAX_RETRY)) begin
              fail  <= 1'b1;
              state <= ST_FIN;
            end else begin
              retry <= retry + RW'(1);
              state <= (state == ST_OFF_CNT) ? ST_OFF_WAIT : ST_GAIN_WAIT;
            end
          end else if (win_last) begin
            tmr   <= '0;
            retry <= '0;
            state <= (state == ST_OFF_CNT) ? ST_GAIN_WAIT : ST_FIN;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdm_cal_seq.sv
module sdm_cal_seq
  import sdm_cal_pkg::*;
#(
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 1000,
  parameter int MIN_LOG    = 10,
  parameter int MAX_LOG    = 20,
  parameter int MAX_RETRY  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bip_sel,
  input  logic [4:0]  win_log2,
  input  logic        mod_valid,
  input  logic        bit_a,
  input  logic        bit_b,
  output logic        mod_rst,
  output logic        zero_cal,
  output logic        gain_cal,
  output logic        mod_bip,
  output logic [20:0] off_err_a,
  output logic [20:0] off_err_b,
  output logic [20:0] gain_err_a,
  output logic [20:0] gain_err_b,
  output logic        busy,
  output logic        cal_done,
  output logic        cal_error,
  output logic        stale
);
  localparam int CW = MAX_LOG + 1;
  localparam int NCH = 2;

  logic          run_bip, cnt_clr, cnt_en, store_off, store_gain;
  logic [4:0]    run_log;
  logic [CW-1:0] ideal;
  logic [NCH-1:0] bits;
  logic [CW-1:0] total [NCH];
  logic [CW-1:0] err_now [NCH];
  logic [CW-1:0] off_q [NCH];
  logic [CW-1:0] gain_q [NCH];
  logic          res_ok, res_bip;

  sdm_cal_ctrl #(
    .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .MIN_LOG(MIN_LOG),
    .MAX_LOG(MAX_LOG), .MAX_RETRY(MAX_RETRY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bip_in(bip_sel),
    .win_log2(win_log2), .mod_valid(mod_valid), .mod_rst(mod_rst),
    .zero_cal(zero_cal), .gain_cal(gain_cal), .busy(busy), .done(cal_done),
    .fail(cal_error), .run_bip(run_bip), .run_log(run_log),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en), .store_off(store_off),
    .store_gain(store_gain)
  );

  assign bits  = {bit_b, bit_a};
  assign ideal = CW'(ideal_ones(32'(run_log), gain_cal, run_bip));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [CW:0] diff;
    sdm_ones_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
      .bit_in(bits[c]), .total_next(total[c])
    );
    assign diff       = $signed({1'b0, total[c]}) - $signed({1'b0, ideal});
    assign err_now[c] = diff[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q[c]  <= '0;
        gain_q[c] <= '0;
      end else begin
        if (store_off)  off_q[c]  <= err_now[c];
        if (store_gain) gain_q[c] <= err_now[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ok  <= 1'b0;
      res_bip <= 1'b0;
    end else if (cal_done) begin
      res_ok  <= !cal_error;
      res_bip <= run_bip;
    end
  end

  assign mod_bip    = busy ? run_bip : bip_sel;
  assign stale      = !res_ok || (bip_sel != res_bip);
  assign off_err_a  = 21'(off_q[0]);
  assign off_err_b  = 21'(off_q[1]);
  assign gain_err_a = 21'(gain_q[0]);
  assign gain_err_b = 21'(gain_q[1]);
endmodule

// File: rtl/sdm_cal_seq_chk.sv
module sdm_cal_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mod_rst,
  input logic        zero_cal,
  input logic        gain_cal,
  input logic        mod_bip,
  input logic [20:0] off_err_a,
  input logic [20:0] gain_err_b,
  input logic        busy,
  input logic        cal_done,
  input logic        cal_error,
  input logic        stale
);
  p_ctrl_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_cal && gain_cal));

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!zero_cal && !gain_cal && !mod_rst));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (!cal_done && !busy));

  p_reset_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst) |-> !$past(busy));

  p_fail_stale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && cal_error) |=> stale);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mod_bip));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(off_err_a) && $stable(gain_err_b)));
endmodule

bind sdm_cal_seq sdm_cal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_rst(mod_rst), .zero_cal(zero_cal),
  .gain_cal(gain_cal), .mod_bip(mod_bip), .off_err_a(off_err_a),
  .gain_err_b(gain_err_b), .busy(busy), .cal_done(cal_done),
  .cal_error(cal_error), .stale(stale)
);

// File: tb/sim_sdm_cal_seq.sv
`timescale 1ns/1ps
module sim_sdm_cal_seq;
  localparam int RSTC = 4;
  localparam int SETC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bip_sel = 1'b1;
  logic [4:0] win_log2 = 5'd10;
  logic mod_valid = 1'b1;
  logic bit_a = 1'b0, bit_b = 1'b0;
  logic mod_rst, zero_cal, gain_cal, mod_bip, busy, cal_done, cal_error, stale;
  logic [20:0] off_err_a, off_err_b, gain_err_a, gain_err_b;

  always #2 clk = ~clk;

  sdm_cal_seq #(.RST_CYC(RSTC), .SETTLE_CYC(SETC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bip_sel(bip_sel),
    .win_log2(win_log2), .mod_valid(mod_valid), .bit_a(bit_a), .bit_b(bit_b),
    .mod_rst(mod_rst), .zero_cal(zero_cal), .gain_cal(gain_cal),
    .mod_bip(mod_bip), .off_err_a(off_err_a), .off_err_b(off_err_b),
    .gain_err_a(gain_err_a), .gain_err_b(gain_err_b), .busy(busy),
    .cal_done(cal_done), .cal_error(cal_error), .stale(stale)
  );

  int tests = 0, fails = 0, cycles = 0, runs = 0;
  bit finished = 0;

  // modulator model state
  int ka_off = 4, kb_off = 4, ka_gain = 4, kb_gain = 4;
  int phase = 0, vlow = 0, glow = 0, gcnt = 0;
  bit kill = 0, glitch_arm = 0;
  // monitors
  int rst_len = 0, last_rst_len = 0, rst_rises = 0, gap = 0, last_gap = 0;
  bit in_gap = 0, prev_rst = 0;
  int excl_bad = 0, done_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dens(input int k);
    return (phase < k) ? 1 : 0;
  endfunction

  always @(negedge clk) begin
    cycles++;
    phase = (phase + 1) % 8;
    if (zero_cal) begin
      bit_a = dens(ka_off)[0]; bit_b = dens(kb_off)[0];
    end else if (gain_cal) begin
      bit_a = dens(ka_gain)[0]; bit_b = dens(kb_gain)[0];
    end else begin
      bit_a = dens(4)[0]; bit_b = dens(4)[0];
    end
    if (mod_rst) vlow = 20; else if (vlow > 0) vlow--;
    gcnt = gain_cal ? gcnt + 1 : 0;
    if (glitch_arm && gcnt == SETC + 100) begin glow = 20; glitch_arm = 0; end
    else if (glow > 0) glow--;
    mod_valid = (vlow == 0) && (glow == 0) && !(kill && zero_cal);
    // monitors
    if (mod_rst) begin rst_len++; in_gap = 1; gap = 0; end
    else begin
      if (prev_rst) begin last_rst_len = rst_len; rst_len = 0; rst_rises++; end
      if (in_gap) begin
        if (zero_cal) begin in_gap = 0; last_gap = gap; end else gap++;
      end
    end
    prev_rst = mod_rst;
    if (zero_cal && gain_cal) excl_bad++;
    if (cal_done && (zero_cal || gain_cal || mod_rst)) done_bad++;
    if (cycles > 150000 && !finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int clampl(input int lg);
    return (lg < 10) ? 10 : (lg > 20) ? 20 : lg;
  endfunction

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    runs++;
    chk("R1", "busy after start", busy, 1);
    chk("R1", "mod_rst after start", mod_rst, 1);
    repeat (60) @(negedge clk);
    start = 1'b1;              // R10: must be ignored while busy
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!cal_done) @(negedge clk);
    chk("R8", "controls low at done", int'({zero_cal, gain_cal, mod_rst}), 0);
    @(negedge clk);
    chk("R8", "busy after done", busy, 0);
    chk("R8", "done is one cycle", cal_done, 0);
    chk("R10", "one reset per run", rst_rises, runs);
  endtask

  task automatic run_cal(input string name, input bit bip, input int lg,
                         input int koa, input int kob, input int kga, input int kgb);
    int n, ioff;
    bip_sel = bip; win_log2 = 5'(lg);
    ka_off = koa; kb_off = kob; ka_gain = kga; kb_gain = kgb;
    n = 1 << clampl(lg);
    ioff = bip ? n / 2 : 3 * n / 8;
    kick();
    chk("R2", {name, " mod_bip held"}, mod_bip, bip);
    wait_done();
    chk("R1", {name, " reset length"}, last_rst_len, RSTC);
    chk("R2", {name, " settle gap"}, last_gap, SETC);
    chk("R3", {name, " off a"}, int'($signed(off_err_a)), koa * n / 8 - ioff);
    chk("R3", {name, " off b"}, int'($signed(off_err_b)), kob * n / 8 - ioff);
    chk("R4", {name, " gain a"}, int'($signed(gain_err_a)), kga * n / 8 - 5 * n / 8);
    chk("R4", {name, " gain b"}, int'($signed(gain_err_b)), kgb * n / 8 - 5 * n / 8);
    chk("R9", {name, " stale clear"}, stale, 0);
    chk("R7", {name, " no error"}, cal_error, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy reset", busy, 0);
    chk("R1", "done reset", cal_done, 0);
    chk("R1", "error reset", cal_error, 0);
    chk("R1", "controls reset", int'({mod_rst, zero_cal, gain_cal}), 0);
    chk("R9", "stale reset", stale, 1);
    chk("R2", "mod_bip follows idle", mod_bip, bip_sel);
  endtask

  task automatic t_stale();
    bip_sel = 1'b0; @(negedge clk);
    chk("R9", "stale on mode change", stale, 1);
    chk("R2", "mod_bip follows when idle", mod_bip, 0);
    bip_sel = 1'b1; @(negedge clk);
    chk("R9", "stale back to matching mode", stale, 0);
  endtask

  task automatic t_retry();
    glitch_arm = 1;
    run_cal("R6 retry", 1'b1, 10, 4, 6, 5, 3);
    chk("R6", "glitch consumed", int'(glitch_arm), 0);
  endtask

  task automatic t_fail();
    kill = 1; bip_sel = 1'b1; win_log2 = 5'd10;
    kick();
    wait_done();
    chk("R7", "error flag", cal_error, 1);
    chk("R7", "stale after error", stale, 1);
    kill = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cal("R3 bipolar", 1'b1, 10, 4, 5, 5, 6);
    t_stale();
    run_cal("R3 unipolar", 1'b0, 11, 3, 2, 7, 5);
    t_retry();
    t_fail();
    run_cal("R5 clamp", 1'b1, 5, 4, 5, 1, 8);
    chk("R8", "never both controls", excl_bad, 0);
    chk("R8", "controls at done", done_bad, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule